// File: doc/BRIEF.md
# Dual-Mode Address Generation Unit

This unit keeps the program counter, two stack pointers, an 8-bit page base and the memory-mode flag for a small processor core with a 24-bit address space. From this state it drives two addresses on every cycle: the instruction fetch address and the current top-of-stack address. Both addresses come straight from registers.

The core can run in one of two modes. In paged mode, 16-bit offsets sit inside a 64 KB window, and the page base supplies the upper eight address bits. In flat mode, addresses are full 24-bit values.

The instruction sequencer controls the unit through single-cycle strobes:
- fetch advance
- jump with a target
- push
- pop
- mode change with the new mode value
- page-base write

The mode flag changes only through its own strobe. The sequencer raises that strobe for mode-changing control transfers and for interrupt or trap entry. No data write can reach the mode flag.

Top module: `addr_gen_unit`

## Requirements
- R1: After a synchronous reset, the mode flag is 0 (paged), and the program counter, both stack pointers and the page base are zero. As a result, the fetch and stack addresses both read 0x000000.
- R2: The mode flag takes the value of `mode_val_i` one cycle after `mode_set_i` is high. Otherwise it keeps its value, and a page-base write does not alter it.
- R3: In paged mode (flag 0), the fetch address is {page base, PC[15:0]}. In flat mode (flag 1), it is PC[23:0].
- R4: Each cycle with `adv_i` high adds 1 to the PC. In paged mode, 0xFFFF wraps to 0x0000 and the page base is left unchanged. In flat mode, 0xFFFFFF wraps to 0x000000.
- R5: A jump loads the target into the PC, and a jump wins over an advance in the same cycle. In paged mode, only target bits 15:0 are kept and PC[23:16] is zero.
- R6: In paged mode, a push lowers the 16-bit short pointer by 2 and a pop raises it by 2. The pointer wraps within 16 bits, and the stack address is {page base, short pointer}.
- R7: In flat mode, a push lowers the 24-bit long pointer by 3 and a pop raises it by 3. The stack address is the long pointer. A pointer that belongs to the inactive mode never changes.
- R8: A push and a pop in the same cycle leave both stack pointers unchanged.
- R9: A page-base write shows on the fetch and stack addresses from the next cycle on. In flat mode, it has no effect on either address.
- R10: When the mode becomes paged, PC[23:16] is cleared in the same update. A jump in the same cycle as a mode change is interpreted in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance PC by one fetched byte |
| jmp_i | input | 1 | Load PC from jump target |
| jmp_target_i | input | 24 | Jump target |
| push_i | input | 1 | Push: pre-decrement the active stack pointer |
| pop_i | input | 1 | Pop: post-increment the active stack pointer |
| mode_set_i | input | 1 | Mode change strobe (control transfer or interrupt/trap entry) |
| mode_val_i | input | 1 | New mode: 0 paged, 1 flat |
| page_we_i | input | 1 | Page base write enable |
| page_wdata_i | input | 8 | Page base write data |
| fetch_addr_o | output | 24 | Instruction fetch address |
| stack_addr_o | output | 24 | Top-of-stack address |
| mode_o | output | 1 | Current mode flag |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, an 8-bit page base, and steps of 2 and 3 bytes. Because every register resets to zero, the first push in either mode immediately reaches the pointer wrap, at 0xFFFE and 0xFFFFFD. A jump to 0xFFFF or 0xFFFFFF puts both PC wraps within two cycles. The pointer of the inactive mode is observed by switching modes and reading the stack address.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int ADDR_W     = 24;
    localparam int PAGE_W     = 8;
    localparam int SHORT_STEP = 2;
    localparam int LONG_STEP  = 3;

    typedef enum logic {
        MODE_PAGED = 1'b0,
        MODE_FLAT  = 1'b1
    } amode_t;
endpackage

// File: rtl/agu_mode.sv
module agu_mode
    import agu_pkg::*;
#(
    parameter int PAGE_W_P = PAGE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_set_i,
    input  logic                mode_val_i,
    input  logic                page_we_i,
    input  logic [PAGE_W_P-1:0] page_wdata_i,
    output amode_t              mode_q_o,
    output amode_t              mode_nxt_o,
    output logic [PAGE_W_P-1:0] page_q_o
);
    amode_t              mode_q;
    logic [PAGE_W_P-1:0] page_q;

    always_comb mode_nxt_o = mode_set_i ? amode_t'(mode_val_i) : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PAGED;
            page_q <= '0;
        end else begin
            mode_q <= mode_nxt_o;
            if (page_we_i) page_q <= page_wdata_i;
        end
    end

    assign mode_q_o = mode_q;
    assign page_q_o = page_q;

    // R1: reset returns to paged mode
    a_r1_mode_reset: assert property (@(posedge clk) rst |=> mode_q == MODE_PAGED);
    // R2: mode only moves on its own strobe
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !mode_set_i |=> $stable(mode_q));
    a_r2_mode_load: assert property (@(posedge clk) disable iff (rst)
        mode_set_i |=> mode_q == amode_t'($past(mode_val_i)));
    // R9: page base only moves on a write
    a_r9_page_hold: assert property (@(posedge clk) disable iff (rst)
        !page_we_i |=> $stable(page_q));
endmodule

// File: rtl/agu_pc.sv
module agu_pc
    import agu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int PAGE_W_P = PAGE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  amode_t              mode_nxt_i,
    input  logic                adv_i,
    input  logic                jmp_i,
    input  logic [ADDR_W_P-1:0] target_i,
    output logic [ADDR_W_P-1:0] pc_o
);
    localparam int OFS_W = ADDR_W_P - PAGE_W_P;

    logic [ADDR_W_P-1:0] pc_q;
    logic [ADDR_W_P-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        if (jmp_i) begin
            pc_d = target_i;
        end else if (adv_i) begin
            if (mode_nxt_i == MODE_FLAT)
                pc_d = pc_q + ADDR_W_P'(1);
            else
                pc_d[OFS_W-1:0] = pc_q[OFS_W-1:0] + OFS_W'(1);
        end
        if (mode_nxt_i == MODE_PAGED)
            pc_d[ADDR_W_P-1:OFS_W] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    // R5: flat jump lands exactly on the target
    a_r5_flat_jump: assert property (@(posedge clk) disable iff (rst)
        (jmp_i && mode_nxt_i == MODE_FLAT) |=> pc_q == $past(target_i));
    // R4: flat advance without jump moves by one
    a_r4_flat_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !jmp_i && mode_nxt_i == MODE_FLAT) |=> pc_q == $past(pc_q) + ADDR_W_P'(1));
endmodule

// File: rtl/agu_stack.sv
module agu_stack
    import agu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int PAGE_W_P = PAGE_W,
    parameter int SHORT_P  = SHORT_STEP,
    parameter int LONG_P   = LONG_STEP
) (
    input  logic                        clk,
    input  logic                        rst,
    input  amode_t                      mode_i,
    input  logic                        push_i,
    input  logic                        pop_i,
    output logic [ADDR_W_P-PAGE_W_P-1:0] sps_o,
    output logic [ADDR_W_P-1:0]         spl_o
);
    localparam int OFS_W = ADDR_W_P - PAGE_W_P;

    logic [OFS_W-1:0]    sps_q, sps_d;
    logic [ADDR_W_P-1:0] spl_q, spl_d;
    logic                moves;

    assign moves = push_i ^ pop_i;

    always_comb begin
        sps_d = sps_q;
        spl_d = spl_q;
        if (moves) begin
            if (mode_i == MODE_FLAT)
                spl_d = push_i ? spl_q - ADDR_W_P'(LONG_P) : spl_q + ADDR_W_P'(LONG_P);
            else
                sps_d = push_i ? sps_q - OFS_W'(SHORT_P) : sps_q + OFS_W'(SHORT_P);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sps_q <= '0;
            spl_q <= '0;
        end else begin
            sps_q <= sps_d;
            spl_q <= spl_d;
        end
    end

    assign sps_o = sps_q;
    assign spl_o = spl_q;

    // R7: the inactive pointer never moves
    a_r7_spl_idle: assert property (@(posedge clk) disable iff (rst)
        mode_i == MODE_PAGED |=> $stable(spl_q));
    a_r7_sps_idle: assert property (@(posedge clk) disable iff (rst)
        mode_i == MODE_FLAT |=> $stable(sps_q));
    // R8: simultaneous push and pop cancel
    a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> ($stable(sps_q) && $stable(spl_q)));
    // R6: a paged pop undoes a paged push
    a_r6_short_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && mode_i == MODE_PAGED) |=> sps_q - OFS_W'(SHORT_P) == $past(sps_q));
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int PAGE_W_P = PAGE_W,
    parameter int SHORT_P  = SHORT_STEP,
    parameter int LONG_P   = LONG_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_i,
    input  logic                jmp_i,
    input  logic [ADDR_W_P-1:0] jmp_target_i,
    input  logic                push_i,
    input  logic                pop_i,
    input  logic                mode_set_i,
    input  logic                mode_val_i,
    input  logic                page_we_i,
    input  logic [PAGE_W_P-1:0] page_wdata_i,
    output logic [ADDR_W_P-1:0] fetch_addr_o,
    output logic [ADDR_W_P-1:0] stack_addr_o,
    output logic                mode_o
);
    localparam int OFS_W = ADDR_W_P - PAGE_W_P;

    amode_t              mode_q, mode_nxt;
    logic [PAGE_W_P-1:0] page_q;
    logic [ADDR_W_P-1:0] pc_q, spl_q;
    logic [OFS_W-1:0]    sps_q;

    agu_mode #(.PAGE_W_P(PAGE_W_P)) u_mode (
        .clk(clk), .rst(rst),
        .mode_set_i(mode_set_i), .mode_val_i(mode_val_i),
        .page_we_i(page_we_i), .page_wdata_i(page_wdata_i),
        .mode_q_o(mode_q), .mode_nxt_o(mode_nxt), .page_q_o(page_q)
    );

    agu_pc #(.ADDR_W_P(ADDR_W_P), .PAGE_W_P(PAGE_W_P)) u_pc (
        .clk(clk), .rst(rst), .mode_nxt_i(mode_nxt),
        .adv_i(adv_i), .jmp_i(jmp_i), .target_i(jmp_target_i),
        .pc_o(pc_q)
    );

    agu_stack #(.ADDR_W_P(ADDR_W_P), .PAGE_W_P(PAGE_W_P),
                .SHORT_P(SHORT_P), .LONG_P(LONG_P)) u_stack (
        .clk(clk), .rst(rst), .mode_i(mode_q),
        .push_i(push_i), .pop_i(pop_i),
        .sps_o(sps_q), .spl_o(spl_q)
    );

    always_comb begin
        if (mode_q == MODE_FLAT) begin
            fetch_addr_o = pc_q;
            stack_addr_o = spl_q;
        end else begin
            fetch_addr_o = {page_q, pc_q[OFS_W-1:0]};
            stack_addr_o = {page_q, sps_q};
        end
    end

    assign mode_o = (mode_q == MODE_FLAT);

    // R10: paged mode keeps PC upper bits at zero
    a_r10_pc_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !mode_o |-> pc_q[ADDR_W_P-1:OFS_W] == '0);
    // R3: paged addresses carry the page base
    a_r3_page_join: assert property (@(posedge clk) disable iff (rst)
        !mode_o |-> (fetch_addr_o[ADDR_W_P-1:OFS_W] == page_q &&
                     stack_addr_o[ADDR_W_P-1:OFS_W] == page_q));
endmodule

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv_i, jmp_i, push_i, pop_i, mode_set_i, mode_val_i, page_we_i;
    logic [23:0] jmp_target_i;
    logic [7:0]  page_wdata_i;
    logic [23:0] fetch_addr_o, stack_addr_o;
    logic        mode_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_gen_unit uut (
        .clk(clk), .rst(rst), .adv_i(adv_i), .jmp_i(jmp_i),
        .jmp_target_i(jmp_target_i), .push_i(push_i), .pop_i(pop_i),
        .mode_set_i(mode_set_i), .mode_val_i(mode_val_i),
        .page_we_i(page_we_i), .page_wdata_i(page_wdata_i),
        .fetch_addr_o(fetch_addr_o), .stack_addr_o(stack_addr_o), .mode_o(mode_o)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        adv_i = 0; jmp_i = 0; push_i = 0; pop_i = 0;
        mode_set_i = 0; mode_val_i = 0; page_we_i = 0;
        jmp_target_i = '0; page_wdata_i = '0;
    endtask

    // hold current strobes through one rising edge, then clear them
    task automatic cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        chk("R1 fetch", fetch_addr_o, 24'h000000);
        chk("R1 stack", stack_addr_o, 24'h000000);
        chk("R1 mode", {23'd0, mode_o}, 24'd0);
    endtask

    task automatic t_paged_pc();
        page_we_i = 1; page_wdata_i = 8'h5A; cycle();
        chk("R9 page to fetch", fetch_addr_o, 24'h5A0000);
        chk("R2 mode after page write", {23'd0, mode_o}, 24'd0);
        jmp_i = 1; jmp_target_i = 24'h12FFFE; cycle();
        chk("R5 paged jump", fetch_addr_o, 24'h5AFFFE);
        adv_i = 1; cycle();
        chk("R4 paged adv", fetch_addr_o, 24'h5AFFFF);
        adv_i = 1; cycle();
        chk("R4 paged wrap", fetch_addr_o, 24'h5A0000);
        jmp_i = 1; adv_i = 1; jmp_target_i = 24'h001234; cycle();
        chk("R5 jump beats adv", fetch_addr_o, 24'h5A1234);
    endtask

    task automatic t_paged_stack();
        push_i = 1; cycle();
        chk("R6 push wrap", stack_addr_o, 24'h5AFFFE);
        push_i = 1; cycle();
        chk("R6 push", stack_addr_o, 24'h5AFFFC);
        pop_i = 1; cycle();
        chk("R6 pop", stack_addr_o, 24'h5AFFFE);
        pop_i = 1; cycle();
        chk("R6 pop wrap", stack_addr_o, 24'h5A0000);
        push_i = 1; pop_i = 1; cycle();
        chk("R8 push+pop paged", stack_addr_o, 24'h5A0000);
    endtask

    task automatic t_flat();
        mode_set_i = 1; mode_val_i = 1; cycle();
        chk("R2 mode set", {23'd0, mode_o}, 24'd1);
        chk("R3 flat fetch", fetch_addr_o, 24'h001234);
        chk("R7 long ptr untouched", stack_addr_o, 24'h000000);
        push_i = 1; cycle();
        chk("R7 flat push wrap", stack_addr_o, 24'hFFFFFD);
        push_i = 1; cycle();
        chk("R7 flat push", stack_addr_o, 24'hFFFFFA);
        pop_i = 1; cycle();
        chk("R7 flat pop", stack_addr_o, 24'hFFFFFD);
        push_i = 1; pop_i = 1; cycle();
        chk("R8 push+pop flat", stack_addr_o, 24'hFFFFFD);
        page_we_i = 1; page_wdata_i = 8'h33; cycle();
        chk("R9 flat fetch ignores page", fetch_addr_o, 24'h001234);
        chk("R9 flat stack ignores page", stack_addr_o, 24'hFFFFFD);
        jmp_i = 1; jmp_target_i = 24'hABCDEF; cycle();
        chk("R5 flat jump", fetch_addr_o, 24'hABCDEF);
        adv_i = 1; cycle();
        chk("R4 flat adv", fetch_addr_o, 24'hABCDF0);
        jmp_i = 1; jmp_target_i = 24'hFFFFFF; cycle();
        adv_i = 1; cycle();
        chk("R4 flat wrap", fetch_addr_o, 24'h000000);
        chk("R2 mode holds", {23'd0, mode_o}, 24'd1);
    endtask

    task automatic t_mode_switch();
        jmp_i = 1; jmp_target_i = 24'h7FFFFF; cycle();
        mode_set_i = 1; mode_val_i = 0; cycle();
        chk("R10 upper cleared", fetch_addr_o, 24'h33FFFF);
        chk("R7 short ptr untouched", stack_addr_o, 24'h330000);
        mode_set_i = 1; mode_val_i = 1; jmp_i = 1; jmp_target_i = 24'hC0FFEE; cycle();
        chk("R10 jump into flat", fetch_addr_o, 24'hC0FFEE);
        chk("R7 long ptr kept", stack_addr_o, 24'hFFFFFD);
        mode_set_i = 1; mode_val_i = 0; jmp_i = 1; jmp_target_i = 24'hC0FFEE; cycle();
        chk("R10 jump into paged", fetch_addr_o, 24'h33FFEE);
        chk("R2 mode cleared", {23'd0, mode_o}, 24'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_paged_pc();
        t_paged_stack();
        t_flat();
        t_mode_switch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule